// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero Insertion

This block turns host bytes into a serial HDLC bit stream. The host hands it bytes one at a time through a single holding register and is paced by a ready flag, which can also raise an interrupt request. The framer sends one bit on each clock where the bit-enable tick is high. While it has nothing to send it fills the line with back-to-back flags. It starts a frame as soon as a byte is waiting at the end of a flag, so that flag serves as the opening flag.

Bytes go out least significant bit first. A zero bit is inserted after any five ones in a row in the data or check field. When the host stops supplying bytes, the frame is closed at the next byte boundary. The framer then appends a 16-bit frame check sequence and a closing flag. That flag also serves as the opening flag when the host has already written the first byte of the next frame. A status bit follows the close: it rises when the frame is closed and falls when the closing flag starts. On request, the host can also abort the frame being sent, with a run of ones.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `enable` is 0 (and in reset) `txBit` is 1, `txReady`, `irq` and `txEnd` are 0, host writes are dropped, and no flag is sent.
- R2: With `enable` at 1 and no byte waiting, the line carries back-to-back flags: byte 0x7E sent least significant bit first, i.e. the bit order 0,1,1,1,1,1,1,0.
- R3: A frame goes out as flag, then the data bytes in write order (each least significant bit first), then two check bytes, then a closing flag.
- R4: Within the data and check fields a 0 is inserted after every five consecutive 1 bits, including a run that ends a field. Flag bits are never stuffed.
- R5: The check field is the ones' complement of a CRC with polynomial x^16+x^12+x^5+1 and preset 0xFFFF. It is computed over the data bits without inserted zeros, least significant bit of each byte first, and sent low byte first, each byte least significant bit first.
- R6: A byte written while the check field is being sent starts a new frame right after the closing flag, with no extra flag between the frames.
- R7: `txReady` is 1 when enabled and the holding register is empty. A write with `wrValid` while `txReady` is 1 is taken and drops `txReady`. A write while `txReady` is 0 has no effect.
- R8: `irq` is 1 exactly when `txReady` and `irqEn` are both 1.
- R9: If the holding register is empty when a data byte's last bit goes out, the frame is closed and `txEnd` rises on that tick. This is at least 8 ticks after `txReady` rose for that byte.
- R10: `txEnd` falls on the tick that sends the first bit of the closing flag. That flag completes 7 ticks later.
- R11: An `abortReq` pulse during the data or check field sends eight unstuffed 1 bits, empties the holding register, clears `txEnd` and returns to flags. A pulse while only flags are being sent is ignored.
- R12: While enabled, `txBit` changes only on clocks where `bitTick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Framing enable; 0 holds the block idle and cleared |
| bitTick | input | 1 | One line bit is sent on each clock where this is 1 |
| wrValid | input | 1 | Host write strobe for the holding register |
| wrData | input | 8 | Host byte |
| irqEn | input | 1 | Interrupt enable for the ready flag |
| abortReq | input | 1 | Pulse to abort the frame in progress |
| txReady | output | 1 | Holding register can take a byte |
| irq | output | 1 | Ready interrupt request |
| txEnd | output | 1 | Frame closed; check field being sent |
| txBit | output | 1 | Serial line bit |

## Verification
The bench decodes the line as a receiver would: it finds flags, removes stuffed zeros and recomputes the check field, and it sweeps frames of one to six bytes plus one frame carrying all 256 byte values. All-ones and 0x7E payloads aim at stuffing across byte and field edges. A missing stuff bit would show up as a false flag or abort, and a stuff bit left out before the closing flag would corrupt that flag. Back-to-back frames written during the check field catch a design that adds an extra flag or merges the two frames. The bench also times `txEnd` against the ready flag and the closing flag, which catches a status that rises early or falls a flag late. Aborts are tested both inside a frame and during idle flags: the first must drop the frame and free the holding register, and the second must leave the flags unbroken.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam logic [7:0] FLAG_BYTE = 8'h7E;

  typedef enum logic [2:0] {
    ST_OFF, ST_FLAG, ST_DATA, ST_CRC, ST_ABORT
  } txState_t;

  typedef enum logic [1:0] {
    SRC_CONST, SRC_DATA, SRC_CRC
  } bitSrc_t;

  typedef struct packed {
    logic    clear;
    logic    open;
    logic    emit;
    bitSrc_t src;
    logic    constBit;
    logic    loadByte;
    logic    shiftData;
    logic    crcInit;
    logic    shiftCrc;
    logic    flush;
  } txStrobe_t;
endpackage

// File: rtl/hdlc_tx_datapath.sv
module hdlc_tx_datapath
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              holdFull,
  output logic              dataBit,
  output logic              crcBit,
  output logic              txBit
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [CRC_W-1:0]  crcReg;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    crcStep = (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY : '0);
  endfunction

  assign dataBit = shiftReg[0];
  assign crcBit  = ~crcReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shiftReg <= '0;
      crcReg   <= CRC_INIT;
      txBit    <= 1'b1;
    end else if (stb.clear) begin
      holdFull <= 1'b0;
      txBit    <= 1'b1;
    end else begin
      if (stb.flush || stb.loadByte) begin
        holdFull <= 1'b0;
      end else if (wrValid && stb.open && !holdFull) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end

      if (stb.loadByte)       shiftReg <= holdReg;
      else if (stb.shiftData) shiftReg <= shiftReg >> 1;

      if (stb.crcInit)        crcReg <= CRC_INIT;
      else if (stb.shiftData) crcReg <= crcStep(crcReg, shiftReg[0]);
      else if (stb.shiftCrc)  crcReg <= crcReg >> 1;

      if (stb.emit) begin
        case (stb.src)
          SRC_DATA: txBit <= shiftReg[0];
          SRC_CRC:  txBit <= ~crcReg[0];
          default:  txBit <= stb.constBit;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W = 16,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      bitTick,
  input  logic      abortReq,
  input  logic      holdFull,
  input  logic      dataBit,
  input  logic      crcBit,
  output txStrobe_t stb,
  output logic      txEnd
);
  localparam int CNT_W  = $clog2(CRC_W);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0]  BYTE_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0]  CRC_LAST   = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0]  ABORT_LAST = CNT_W'(ABORT_LEN - 1);
  localparam logic [ONES_W-1:0] ONES_MAX   = ONES_W'(STUFF_RUN);

  txState_t          state, nState;
  logic [CNT_W-1:0]  bitCnt, nCnt;
  logic [ONES_W-1:0] onesCnt, nOnes;
  logic              nEnd, abortPend, nAbort, stuffDue;

  assign stuffDue = (onesCnt == ONES_MAX);

  always_comb begin
    nState = state;
    nCnt   = bitCnt;
    nOnes  = onesCnt;
    nEnd   = txEnd;
    nAbort = abortPend | abortReq;
    stb    = '0;
    stb.clear = !enable;
    stb.open  = (state != ST_OFF);
    if (!enable) begin
      nState = ST_OFF;
      nCnt   = '0;
      nOnes  = '0;
      nEnd   = 1'b0;
      nAbort = 1'b0;
    end else if (state == ST_OFF) begin
      nState = ST_FLAG;
      nCnt   = '0;
    end else if (bitTick) begin
      stb.emit = 1'b1;
      stb.src  = SRC_CONST;
      case (state)
        ST_FLAG: begin
          nAbort = 1'b0;
          nOnes  = '0;
          if (stuffDue) begin
            stb.constBit = 1'b0;
          end else begin
            stb.constBit = FLAG_BYTE[bitCnt[2:0]];
            if (bitCnt == '0) nEnd = 1'b0;
            if (bitCnt == BYTE_LAST) begin
              nCnt = '0;
              if (holdFull) begin
                stb.loadByte = 1'b1;
                stb.crcInit  = 1'b1;
                nState       = ST_DATA;
              end
            end else begin
              nCnt = bitCnt + 1'b1;
            end
          end
        end
        ST_DATA, ST_CRC: begin
          if (abortPend) begin
            stb.constBit = 1'b1;
            stb.flush    = 1'b1;
            nState = ST_ABORT;
            nCnt   = CNT_W'(1);
            nOnes  = '0;
            nEnd   = 1'b0;
            nAbort = 1'b0;
          end else if (stuffDue) begin
            stb.constBit = 1'b0;
            nOnes = '0;
          end else if (state == ST_DATA) begin
            stb.src       = SRC_DATA;
            stb.shiftData = 1'b1;
            nOnes = dataBit ? onesCnt + 1'b1 : '0;
            if (bitCnt == BYTE_LAST) begin
              nCnt = '0;
              if (holdFull) begin
                stb.loadByte = 1'b1;
              end else begin
                nState = ST_CRC;
                nEnd   = 1'b1;
              end
            end else begin
              nCnt = bitCnt + 1'b1;
            end
          end else begin
            stb.src      = SRC_CRC;
            stb.shiftCrc = 1'b1;
            nOnes = crcBit ? onesCnt + 1'b1 : '0;
            if (bitCnt == CRC_LAST) begin
              nCnt   = '0;
              nState = ST_FLAG;
            end else begin
              nCnt = bitCnt + 1'b1;
            end
          end
        end
        default: begin
          stb.constBit = 1'b1;
          nAbort = 1'b0;
          nOnes  = '0;
          if (bitCnt == ABORT_LAST) begin
            nCnt   = '0;
            nState = ST_FLAG;
          end else begin
            nCnt = bitCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OFF;
      bitCnt    <= '0;
      onesCnt   <= '0;
      txEnd     <= 1'b0;
      abortPend <= 1'b0;
    end else begin
      state     <= nState;
      bitCnt    <= nCnt;
      onesCnt   <= nOnes;
      txEnd     <= nEnd;
      abortPend <= nAbort;
    end
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bitTick,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqEn,
  input  logic              abortReq,
  output logic              txReady,
  output logic              irq,
  output logic              txEnd,
  output logic              txBit
);
  txStrobe_t stb;
  logic holdFull, dataBit, crcBit;

  hdlc_tx_ctrl #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .STUFF_RUN(STUFF_RUN), .ABORT_LEN(ABORT_LEN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
    .abortReq(abortReq), .holdFull(holdFull), .dataBit(dataBit),
    .crcBit(crcBit), .stb(stb), .txEnd(txEnd)
  );

  hdlc_tx_datapath #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrValid(wrValid), .wrData(wrData),
    .holdFull(holdFull), .dataBit(dataBit), .crcBit(crcBit), .txBit(txBit)
  );

  assign txReady = stb.open && !holdFull;
  assign irq     = txReady && irqEn;
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic bitTick,
  input logic wrValid,
  input logic txReady,
  input logic txEnd,
  input logic txBit
);
  // R1
  off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txBit && !txReady && !txEnd));

  // R12
  tick_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !bitTick) |=> $stable(txBit));

  // R7
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> ($past(wrValid) || !$past(enable)));

  // R9
  end_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> ($past(bitTick) && $past(txReady)));

  // R10
  end_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txEnd) && $past(enable)) |-> $past(bitTick));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk i_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
  .wrValid(wrValid), .txReady(txReady), .txEnd(txEnd), .txBit(txBit)
);

// File: tb/test_hdlc_tx_framer.sv
module test_hdlc_tx_framer;
  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, bitTick = 1'b0;
  logic wrValid = 1'b0, irqEn = 1'b0, abortReq = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic txReady, irq, txEnd, txBit;

  always #10 clk = ~clk;

  hdlc_tx_framer i_hdlc_tx_framer (
    .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick),
    .wrValid(wrValid), .wrData(wrData), .irqEn(irqEn), .abortReq(abortReq),
    .txReady(txReady), .irq(irq), .txEnd(txEnd), .txBit(txBit)
  );

  int nChecks = 0, nFails = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected frames
  logic [7:0] expData [0:2047];
  int frStart [0:127], frLen [0:127];
  bit frAbort [0:127], frB2B [0:127], frOnes [0:127];
  int nFrames = 0, dataPtr = 0;

  // receiver state
  bit monOn = 0, hunting = 1, prevReady = 0, prevEnd = 0;
  logic lastBit = 1'b1;
  logic [7:0] win = 8'h00;
  logic bitBuf [0:4095];
  int nBits = 0, run = 0, tickIdx = 0, lastReadyRise = 0, lastEndFall = -100;
  int idleFlags = 0, abortSeen = 0, rxIdx = 0, stuffCnt = 0;

  initial begin
    int phase;
    phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % 4;
      bitTick = (phase == 0);
    end
  end

  function automatic logic [7:0] rxByte(input int j);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = bitBuf[j*8+k];
    return v;
  endfunction

  function automatic logic [15:0] benchFcs(input int start, input int len);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++)
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ expData[start+i][k];
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic decodeFrame();
    int fb, n, e, bad;
    logic [15:0] fcs;
    fb = nBits - 8;
    check(fb % 8 == 0 && fb >= 24, "R3 frame bit count", fb, 24);
    if (rxIdx >= nFrames || frAbort[rxIdx]) begin
      check(0, "R3 unexpected frame", rxIdx, nFrames);
    end else if (fb % 8 == 0 && fb >= 24) begin
      e = rxIdx;
      n = fb / 8 - 2;
      check(n == frLen[e], "R3 frame length", n, frLen[e]);
      bad = 0;
      for (int j = 0; j < n && j < frLen[e]; j++)
        if (rxByte(j) != expData[frStart[e]+j]) bad++;
      check(bad == 0, "R3 R4 data bytes", bad, 0);
      fcs = benchFcs(frStart[e], frLen[e]);
      check({rxByte(n+1), rxByte(n)} == fcs, "R5 check field",
            int'({rxByte(n+1), rxByte(n)}), int'(fcs));
      if (frB2B[e]) check(idleFlags == 0, "R6 shared flag", idleFlags, 0);
      check(lastEndFall == tickIdx - 7, "R10 closing flag timing", lastEndFall, tickIdx - 7);
      if (frOnes[e]) check(stuffCnt >= 8 * n / 5, "R4 zero insertion count", stuffCnt, 8 * n / 5);
      rxIdx++;
    end
    idleFlags = 0;
  endtask

  task automatic processBit();
    logic b;
    bit stuffed;
    b = txBit;
    tickIdx++;
    lastBit = b;
    check(irq == (txReady && irqEn), "R8 irq", int'(irq), int'(txReady && irqEn));
    if (txReady && !prevReady) lastReadyRise = tickIdx;
    prevReady = txReady;
    if (txEnd && !prevEnd)
      check(tickIdx - lastReadyRise >= 8, "R9 end after ready", tickIdx - lastReadyRise, 8);
    if (!txEnd && prevEnd) begin
      lastEndFall = tickIdx;
      check(b == 1'b0, "R10 end clears at flag start", int'(b), 0);
    end
    prevEnd = txEnd;
    win = {b, win[7:1]};
    stuffed = (!b && run == 5);
    run = b ? run + 1 : 0;
    if (run == 7) begin
      if (!hunting) begin
        abortSeen++;
        if (rxIdx < nFrames && frAbort[rxIdx]) rxIdx++;
        else check(0, "R11 unexpected abort", abortSeen, 0);
      end
      hunting = 1;
      nBits = 0;
    end else if (stuffed) begin
      stuffCnt++;
    end else if (!hunting) begin
      bitBuf[nBits] = b;
      nBits++;
    end
    if (win == 8'h7E) begin
      if (hunting) hunting = 0;
      else if (nBits == 8) idleFlags++;
      else decodeFrame();
      nBits = 0;
      stuffCnt = 0;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (monOn) begin
        if (bitTick) processBit();
        else check(txBit == lastBit, "R12 bit held between ticks", int'(txBit), int'(lastBit));
      end
    end
  end

  task automatic waitTicks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] v);
    while (!txReady) @(negedge clk);
    wrValid = 1'b1;
    wrData  = v;
    @(negedge clk);
    wrData  = ~v;             // not ready now: must be ignored
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  function automatic logic [7:0] patByte(input int f, input int i);
    case (f % 4)
      0: return 8'hFF;
      1: return 8'h7E;
      2: return 8'((f * 29 + i * 53) & 255);
      default: return (i % 2 == 1) ? 8'hF8 : 8'h1F;
    endcase
  endfunction

  task automatic sendFrame(input int len, input bit b2b, input bit ones, input int kind);
    int e;
    e = nFrames;
    frStart[e] = dataPtr;
    frLen[e] = len;
    frAbort[e] = 0;
    frB2B[e] = b2b;
    frOnes[e] = ones;
    for (int i = 0; i < len; i++)
      expData[dataPtr+i] = (kind < 0) ? 8'(i) : patByte(kind, i);
    nFrames++;
    for (int i = 0; i < len; i++) writeByte(expData[dataPtr+i]);
    dataPtr += len;
    wait (txEnd == 1'b1);
    @(negedge clk);
  endtask

  task automatic settle();
    wait (txEnd == 1'b0);
    waitTicks(20);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(txBit == 1'b1, "R1 reset line idle", int'(txBit), 1);
    check(txReady == 1'b0 && irq == 1'b0, "R1 reset ready/irq", int'(txReady), 0);
    check(txEnd == 1'b0, "R1 reset end status", int'(txEnd), 0);
    rstN = 1'b1;
    irqEn = 1'b1;
    wrValid = 1'b1;
    wrData = 8'h55;
    waitTicks(20);
    wrValid = 1'b0;
    check(txBit == 1'b1 && txReady == 1'b0, "R1 disabled line", int'(txBit), 1);
    check(irq == 1'b0, "R1 disabled irq", int'(irq), 0);

    monOn = 1;
    enable = 1'b1;
    waitTicks(40);
    check(idleFlags >= 3, "R2 idle flags", idleFlags, 3);
    check(txReady == 1'b1, "R7 ready once enabled", int'(txReady), 1);

    // abort request while only flags are sent
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    waitTicks(30);
    check(abortSeen == 0, "R11 idle abort ignored", abortSeen, 0);
    check(idleFlags >= 6, "R2 flags continue", idleFlags, 6);
    idleFlags = 0;

    // sweep of short frames
    for (int f = 0; f < 40; f++) begin
      bit b2b;
      b2b = (f > 0) && (f % 3 != 0);
      if (!b2b) settle();
      irqEn = f[0];
      sendFrame(f % 6 + 1, b2b, (f % 4 == 0), f);
    end

    // every byte value in one frame
    settle();
    sendFrame(256, 0, 0, -1);
    settle();

    // abort inside a frame
    frStart[nFrames] = dataPtr;
    frLen[nFrames] = 2;
    frAbort[nFrames] = 1;
    frB2B[nFrames] = 0;
    frOnes[nFrames] = 0;
    nFrames++;
    writeByte(8'h3C);
    writeByte(8'hA7);
    waitTicks(3);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    waitTicks(24);
    check(abortSeen == 1, "R11 abort seen on line", abortSeen, 1);
    check(txReady == 1'b1, "R11 holding register flushed", int'(txReady), 1);
    check(txEnd == 1'b0, "R11 end status clear", int'(txEnd), 0);

    // recovery frame
    sendFrame(3, 0, 0, 6);
    settle();

    check(rxIdx == nFrames, "R3 all frames received", rxIdx, nFrames);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule